// File: doc/BRIEF.md
# Processor Reset Sequencer

This block turns reset requests into a fixed, ordered reset sequence for a processor core. A request comes either from the shared reset pin, when something outside pulls it low, or from a one-cycle underflow pulse raised by the watchdog. Every request starts an active phase whose shape depends on the source. A stabilisation delay follows, whose length a static option input selects. Last comes a two-cycle vector fetch, during which the block presents the two reset-vector addresses to the core, high byte address last. The internal core reset stays asserted from the request until the fetch completes.

The reset pin is modelled as an open-drain line. The block has a drive-low enable output and reads back the sensed pin level. The block captures a low level on the pin asynchronously, so a request is latched even while the clock is stopped. Once the clock runs, it counts the captured level against a minimum width, and short glitches are rejected. While the block drives the pin low itself, the low level it senses is masked and does not count as an outside request. A request that arrives during the delay or the fetch restarts the sequence from the active phase.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst` is high, `core_rst` and `pin_drive_low` are 1 and `vec_fetch` is 0. After `rst` falls, the pin stays driven low for exactly SHORT_DLY cycles (with `long_delay_sel`=0), and then the fetch phase follows.
- R2: A low level on the pin that covers at least EXT_MIN_W rising edges raises `core_rst` on the EXT_MIN_W-th edge. A low level that covers at most EXT_MIN_W-3 edges is ignored, and `core_rst` stays 0. The two-flop capture lengthens the sensed level by two cycles.
- R3: A watchdog pulse holds the pin driven low for WDG_W cycles of active phase, followed directly by the delay phase. The pin is therefore low for WDG_W plus the delay length.
- R4: The delay phase lasts SHORT_DLY cycles when `long_delay_sel`=0 and LONG_DLY cycles when it is 1. `pin_drive_low` is 1 for the whole delay.
- R5: The fetch phase lasts two cycles with `vec_fetch`=1. `vec_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second, and 16'h0000 whenever `vec_fetch` is 0.
- R6: `core_rst` stays 1 from the request through the second fetch cycle. It is 0 from the following cycle on, until the next request.
- R7: A watchdog pulse during the delay or fetch phase restarts the sequence from the watchdog active phase. The fetch stops at once, and the full WDG_W plus delay length follows.
- R8: A low level sensed while the block drives the pin low is not a request. An outside low that starts and ends inside the driven window leaves the sequence length unchanged.
- R9: During an externally started active phase the block does not drive the pin. The delay phase begins on the third rising edge after the pin returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on clear; starts a delay and fetch sequence |
| pin_sense_n | input | 1 | Sensed level of the open-drain reset pin (0 = low) |
| wdg_uflow | input | 1 | One-cycle watchdog underflow request |
| long_delay_sel | input | 1 | Static option: 0 selects SHORT_DLY, 1 selects LONG_DLY |
| pin_drive_low | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| core_rst | output | 1 | Internal reset to the core, active high |
| vec_fetch | output | 1 | Strobe for the two vector fetch cycles |
| vec_addr | output | 16 | Vector address presented during fetch, otherwise zero |

## Verification
The hardest situation to reach is a request that lands inside the two-cycle fetch window. The bench watches `vec_fetch` at each falling edge and raises the watchdog pulse on the exact cycle where the first fetch address appears. A second hard case is an outside low that overlaps a self-driven pin. The bench pulls the pin low well inside a watchdog-started delay and releases it before the fetch, so only the masking logic stands between that low level and a spurious restart. Every cycle the outputs are also compared against a behavioural model that keeps the sensed-pin history and phase counts in plain integers.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACT_EXT,
        PH_ACT_WDG,
        PH_DELAY,
        PH_FETCH_LO,
        PH_FETCH_HI
    } phase_e;

    localparam logic [15:0] VEC_LO = 16'hFFFE;
    localparam logic [15:0] VEC_HI = 16'hFFFF;

    typedef struct packed {
        logic        core_rst;
        logic        drive_low;
        logic        fetch;
        logic [15:0] addr;
    } seq_out_t;

    function automatic seq_out_t decode_phase(phase_e p);
        seq_out_t o;
        o           = '0;
        o.core_rst  = (p != PH_IDLE);
        o.drive_low = (p == PH_ACT_WDG) || (p == PH_DELAY);
        o.fetch     = (p == PH_FETCH_LO) || (p == PH_FETCH_HI);
        if (p == PH_FETCH_LO)      o.addr = VEC_LO;
        else if (p == PH_FETCH_HI) o.addr = VEC_HI;
        return o;
    endfunction

endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_sense_n,
    input  logic drive_low,
    output logic ext_hit
);
    localparam int              CNTW    = $clog2(MIN_W + 1);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(MIN_W - 1);

    logic            ext_async;
    logic            cap1, cap2;
    logic [CNTW-1:0] width_cnt;

    // Outside low only: our own drive must not look like a request.
    assign ext_async = ~pin_sense_n & ~drive_low;

    // Asynchronous capture, synchronous release.
    always_ff @(posedge clk or posedge ext_async) begin
        if (ext_async) begin
            cap1 <= 1'b1;
            cap2 <= 1'b1;
        end else if (rst) begin
            cap1 <= 1'b0;
            cap2 <= 1'b0;
        end else begin
            cap1 <= 1'b0;
            cap2 <= cap1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cap2)           width_cnt <= '0;
        else if (width_cnt != CNT_TOP) width_cnt <= width_cnt + CNTW'(1);
    end

    assign ext_hit = cap2 && (width_cnt == CNT_TOP);

    // R8: three edges of self drive clear the capture chain.
    a_r8_self_drive_masked: assert property (@(posedge clk) disable iff (rst)
        (drive_low && $past(drive_low) && $past(drive_low, 2)) |-> !ext_hit);

endmodule

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
    import rsq_pkg::*;
#(
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096,
    parameter int WDG_W     = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_hit,
    input  logic     wdg_req,
    input  logic     long_sel,
    output seq_out_t so
);
    localparam int MAXC = (LONG_DLY > SHORT_DLY) ?
                          ((LONG_DLY > WDG_W) ? LONG_DLY : WDG_W) :
                          ((SHORT_DLY > WDG_W) ? SHORT_DLY : WDG_W);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WDG_LAST   = CW'(WDG_W - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);

    phase_e        phase;
    logic [CW-1:0] pcnt;
    logic [CW-1:0] dly_last;

    assign dly_last = long_sel ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_DELAY;
            pcnt  <= '0;
        end else if (ext_hit) begin
            phase <= PH_ACT_EXT;
            pcnt  <= '0;
        end else if (wdg_req) begin
            phase <= PH_ACT_WDG;
            pcnt  <= '0;
        end else begin
            case (phase)
                PH_ACT_EXT: begin
                    phase <= PH_DELAY;
                    pcnt  <= '0;
                end
                PH_ACT_WDG: begin
                    if (pcnt == WDG_LAST) begin
                        phase <= PH_DELAY;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + CW'(1);
                    end
                end
                PH_DELAY: begin
                    if (pcnt == dly_last) begin
                        phase <= PH_FETCH_LO;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + CW'(1);
                    end
                end
                PH_FETCH_LO: phase <= PH_FETCH_HI;
                PH_FETCH_HI: phase <= PH_IDLE;
                default:     phase <= PH_IDLE;
            endcase
        end
    end

    assign so = decode_phase(phase);

    // R7: a lone watchdog pulse always lands in its driven active phase.
    a_r7_restart_wdg: assert property (@(posedge clk) disable iff (rst)
        (wdg_req && !ext_hit) |=> (so.drive_low && !so.fetch));

    // R5: fetch addresses come in fixed order.
    a_r5_fetch_order: assert property (@(posedge clk) disable iff (rst)
        (so.fetch && so.addr == VEC_LO && !ext_hit && !wdg_req)
            |=> (so.fetch && so.addr == VEC_HI));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int EXT_MIN_W = 4,
    parameter int WDG_W     = 16,
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_sense_n,
    input  logic        wdg_uflow,
    input  logic        long_delay_sel,
    output logic        pin_drive_low,
    output logic        core_rst,
    output logic        vec_fetch,
    output logic [15:0] vec_addr
);
    localparam int LRW = $clog2(LONG_DLY + WDG_W + 1) + 1;

    logic     ext_hit;
    seq_out_t so;

    rsq_pin_filter #(.MIN_W(EXT_MIN_W)) u_filt (
        .clk         (clk),
        .rst         (rst),
        .pin_sense_n (pin_sense_n),
        .drive_low   (so.drive_low),
        .ext_hit     (ext_hit)
    );

    rsq_phase_fsm #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY),
        .WDG_W     (WDG_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ext_hit  (ext_hit),
        .wdg_req  (wdg_uflow),
        .long_sel (long_delay_sel),
        .so       (so)
    );

    assign pin_drive_low = so.drive_low;
    assign core_rst      = so.core_rst;
    assign vec_fetch     = so.fetch;
    assign vec_addr      = so.addr;

    // Length of the current driven-low stretch of the pin.
    logic [LRW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || !pin_drive_low)   low_run <= '0;
        else if (!(&low_run))        low_run <= low_run + LRW'(1);
    end

    // R4: every driven stretch contains at least a full short delay.
    a_r4_low_through_delay: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drive_low) |-> (low_run >= LRW'(SHORT_DLY)));

    // R6: core reset ends only after the second fetch cycle.
    a_r6_release_after_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> $past(vec_fetch && vec_addr == VEC_HI));

    // R5: fetch happens only with the core held in reset.
    a_r5_fetch_in_reset: assert property (@(posedge clk) disable iff (rst)
        vec_fetch |-> core_rst);

endmodule

// File: tb/sim_reset_sequencer.sv
`timescale 1ns/1ps
module sim_reset_sequencer;
    localparam int EXT_MIN_W = 4;
    localparam int WDG_W     = 16;
    localparam int SHORT_DLY = 256;
    localparam int LONG_DLY  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_low = 1'b0;
    logic        wdg = 1'b0;
    logic        lsel = 1'b0;
    logic        pin_sense_n;
    logic        pin_drive_low, core_rst, vec_fetch;
    logic [15:0] vec_addr;

    int checks = 0, fails = 0;
    int cyc_checks = 0, cyc_fails = 0;
    bit started = 1'b0;

    always #4 clk = ~clk;

    assign pin_sense_n = ~(ext_low | pin_drive_low);

    reset_sequencer #(
        .EXT_MIN_W (EXT_MIN_W),
        .WDG_W     (WDG_W),
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u0 (
        .clk            (clk),
        .rst            (rst),
        .pin_sense_n    (pin_sense_n),
        .wdg_uflow      (wdg),
        .long_delay_sel (lsel),
        .pin_drive_low  (pin_drive_low),
        .core_rst       (core_rst),
        .vec_fetch      (vec_fetch),
        .vec_addr       (vec_addr)
    );

    // Behavioural reference: 0 idle, 1 ext active, 2 wdg active, 3 delay, 4/5 fetch.
    int m_phase = 3, m_pc = 0, m_run = 0;
    bit m_h1 = 1'b0, m_h2 = 1'b0;
    always @(posedge clk) begin
        bit m_now, seen, hit;
        int dly;
        started = 1'b1;
        m_now = ext_low && !(m_phase == 2 || m_phase == 3);
        seen  = m_now || m_h1 || m_h2;
        m_h2  = m_h1;
        m_h1  = m_now;
        if (rst) begin
            m_h1 = 1'b0; m_h2 = 1'b0; m_run = 0; m_phase = 3; m_pc = 0;
        end else begin
            m_run = seen ? m_run + 1 : 0;
            hit   = seen && (m_run >= EXT_MIN_W);
            dly   = lsel ? LONG_DLY : SHORT_DLY;
            if (hit)      begin m_phase = 1; m_pc = 0; end
            else if (wdg) begin m_phase = 2; m_pc = 0; end
            else begin
                case (m_phase)
                    1: begin m_phase = 3; m_pc = 0; end
                    2: if (m_pc == WDG_W - 1) begin m_phase = 3; m_pc = 0; end else m_pc++;
                    3: if (m_pc == dly - 1) begin m_phase = 4; m_pc = 0; end else m_pc++;
                    4: m_phase = 5;
                    5: m_phase = 0;
                    default: m_phase = 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [15:0] ea;
            ea = (m_phase == 4) ? 16'hFFFE : (m_phase == 5) ? 16'hFFFF : 16'h0000;
            cyc_checks++;
            if (core_rst !== (m_phase != 0)) begin
                cyc_fails++;
                $display("FAIL R6 core_rst actual=%0b expected=%0b t=%0t", core_rst, m_phase != 0, $time);
            end
            cyc_checks++;
            if (pin_drive_low !== (m_phase == 2 || m_phase == 3)) begin
                cyc_fails++;
                $display("FAIL R4 pin_drive_low actual=%0b expected=%0b t=%0t",
                         pin_drive_low, (m_phase == 2 || m_phase == 3), $time);
            end
            cyc_checks++;
            if (vec_fetch !== (m_phase >= 4) || vec_addr !== ea) begin
                cyc_fails++;
                $display("FAIL R5 fetch/addr actual=%0b/%h expected=%0b/%h t=%0t",
                         vec_fetch, vec_addr, m_phase >= 4, ea, $time);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report(input int wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks + cyc_checks + wd, fails + cyc_fails + wd);
        $finish;
    endtask

    task automatic count_driven(output int n);
        n = 0;
        while (pin_drive_low && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic fetch_tail(input string req);
        chk(req, vec_fetch, 1, "first fetch strobe");
        chk("R5", vec_addr, 16'hFFFE, "first vector address");
        @(negedge clk);
        chk(req, vec_fetch, 1, "second fetch strobe");
        chk("R5", vec_addr, 16'hFFFF, "second vector address");
        @(negedge clk);
        chk("R6", core_rst, 0, "core reset released after fetch");
        chk("R5", vec_addr, 0, "address idle after fetch");
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (core_rst && n < 10000) begin
            @(negedge clk);
            n++;
        end
        chk("R6", core_rst, 0, "sequence completes");
        repeat (3) @(negedge clk);
    endtask

    task automatic wdg_pulse();
        @(negedge clk);
        wdg = 1'b1;
        @(negedge clk);
        wdg = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1", core_rst, 1, "core reset during rst");
        chk("R1", pin_drive_low, 1, "pin driven during rst");
        chk("R1", vec_fetch, 0, "no fetch during rst");
        rst = 1'b0;
        count_driven(n);
        chk("R1", n, SHORT_DLY, "power-on delay length");
        fetch_tail("R1");
        repeat (3) @(negedge clk);

        // R2 reject: one edge of low level
        @(negedge clk); ext_low = 1'b1;
        @(negedge clk); ext_low = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2", core_rst, 0, "short pulse ignored");

        // R2 accept: four edges
        ext_low = 1'b1;
        repeat (4) @(negedge clk);
        ext_low = 1'b0;
        chk("R2", core_rst, 1, "long pulse accepted");
        wait_idle();

        // R3 watchdog stretch
        wdg_pulse();
        count_driven(n);
        chk("R3", n, WDG_W + SHORT_DLY, "watchdog driven length");
        fetch_tail("R3");
        repeat (3) @(negedge clk);

        // R4 long delay option
        lsel = 1'b1;
        wdg_pulse();
        count_driven(n);
        chk("R4", n, WDG_W + LONG_DLY, "long option driven length");
        fetch_tail("R4");
        lsel = 1'b0;
        repeat (3) @(negedge clk);

        // R7 restart during delay
        wdg_pulse();
        repeat (40) @(negedge clk);
        wdg = 1'b1;
        @(negedge clk);
        wdg = 1'b0;
        count_driven(n);
        chk("R7", n, WDG_W + SHORT_DLY, "restart in delay gives full length");
        fetch_tail("R7");
        repeat (3) @(negedge clk);

        // R7 restart during fetch
        wdg_pulse();
        n = 0;
        while (!vec_fetch && n < 10000) begin
            @(negedge clk);
            n++;
        end
        wdg = 1'b1;
        @(negedge clk);
        wdg = 1'b0;
        chk("R7", vec_fetch, 0, "fetch aborted by request");
        chk("R7", pin_drive_low, 1, "active phase after restart");
        chk("R7", core_rst, 1, "core held after restart");
        wait_idle();

        // R8 outside low inside self-driven window
        wdg_pulse();
        n = 0;
        while (pin_drive_low && n < 10000) begin
            n++;
            if (n == 30) ext_low = 1'b1;
            if (n == 70) ext_low = 1'b0;
            @(negedge clk);
        end
        chk("R8", n, WDG_W + SHORT_DLY, "masked low leaves length unchanged");
        fetch_tail("R8");
        repeat (3) @(negedge clk);

        // R9 external held low
        @(negedge clk);
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        ext_low = 1'b0;
        n = 0;
        while (!pin_drive_low && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R9", n, 3, "undriven cycles after pin release");
        count_driven(n);
        chk("R9", n, SHORT_DLY, "delay after external reset");
        fetch_tail("R9");
        repeat (3) @(negedge clk);

        report(0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired: run hung actual=timeout expected=done");
        report(1);
    end
endmodule